// File: doc/BRIEF.md
# Action Control and Interrupt Register Block

This block is the host-facing register file of one compute action. A host reaches it over a 32-bit AXI-Lite slave port. It launches the action, follows the action's progress and raises one interrupt line. Toward the action core it drives a start level and samples three plain status levels: done, idle and ready. It also holds a small control-word area and a job-data area, and the action reads both through flat output vectors.

A launch stays pending until the action reports ready. Completion is caught as a sticky bit that a read of the control register consumes. With auto-restart enabled, each completion launches the action again. Interrupts pass through two enable levels: one global enable, then a per-source enable for done and one for ready. Both per-source enables sit on top of sticky status bits.

Back-pressure rules on the port:
- A write is taken only when address and data are presented together.
- Reads and writes each allow one transaction in flight.
- A response stays presented until the host takes it.

Top module: `act_ctl_regs`

## Requirements
- R1: A write is accepted in the cycle where AW and W are both valid and no write response is pending. Its response is held until `s_bready`. A read is accepted when no read data is pending, and its data is held stable until `s_rready`.
- R2: Every write response and every read response carries OKAY (2'b00).
- R3: Writing 1 to bit 0 of offset 0x00 sets `act_start_o`, and bit 0 reads back that start level. Writing 0 there has no effect. Once `act_ready_i` is sampled high while start is set, `act_start_o` is low from the next cycle.
- R4: Bit 1 of offset 0x00 is set on a rising edge of `act_done_i`. An accepted read of 0x00 returns the value before clearing and then clears the bit. A rising edge in the same cycle as that read leaves the bit set.
- R5: Bit 7 of offset 0x00 is a read/write auto-restart flag. While it is 1, a rising edge of `act_done_i` sets start again. While it is 0, done leaves start untouched.
- R6: Bits 2 and 3 of offset 0x00 return `act_idle_i` and `act_ready_i` as sampled in the cycle the read is accepted.
- R7: Offset 0x04 bit 0 is the read/write global interrupt enable. Offset 0x08 bits [1:0] are the read/write per-source enables: bit 0 for done, bit 1 for ready.
- R8: In offset 0x0C, bit 0 is set on a rising edge of `act_done_i` and bit 1 on a rising edge of `act_ready_i`. Writing 1 to a bit clears it, and a set in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when the global enable is 1 and at least one status bit is 1 with its per-source enable also 1. It follows register changes in the cycle after the write.
- R10: Offsets 0x10, 0x14, 0x18 and 0x1C return, in that order: the action type parameter, the version parameter, and the low and high halves of the interrupt source address parameter. Writes to them are ignored.
- R11: Offsets 0x100 to 0x10C are four read/write control words with byte strobes, driven on `ctl_words_o` (word n at bits [32n+31:32n]). Word 0 packs the short type in [7:0], the flags in [15:8] and the sequence number in [31:16]. Word 1 holds the return code.
- R12: Offsets 0x110 up to 0x110+4*(JOB_WORDS-1) are read/write job words with byte strobes, driven on `job_words_o` in the same word order.
- R13: Reads of any other offset return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| act_start_o | output | 1 | Launch level to the action |
| act_done_i | input | 1 | Action completion level |
| act_idle_i | input | 1 | Action idle level |
| act_ready_i | input | 1 | Action ready-for-launch level |
| irq_o | output | 1 | Interrupt request |
| ctl_words_o | output | 128 | Control-word area, word 0 in the low bits |
| job_words_o | output | 32*JOB_WORDS | Job-data area, word 0 in the low bits |

## Verification
The bench keeps the default geometry of four control words and 27 job words. With that geometry, the last job word at 0x178 and the first unmapped word after it at 0x17C both fall inside the tested address range. It overrides the type, version and source-address parameters with distinct values, so a swapped or truncated constant word shows up as a miscompare. The done, ready and read timing is driven cycle-exactly, which covers the read that coincides with a completion edge and the auto-restart relaunch.

// File: rtl/act_regs_pkg.sv
`timescale 1ns/1ps
package act_regs_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 8;
  localparam int unsigned WADR_W = 14;
  localparam logic [1:0]  RESP_OKAY = 2'b00;

  // word offsets of the fixed registers
  localparam int unsigned W_CTRL   = 0;
  localparam int unsigned W_GIE    = 1;
  localparam int unsigned W_IIE    = 2;
  localparam int unsigned W_IIS    = 3;
  localparam int unsigned W_TYPE   = 4;
  localparam int unsigned W_VER    = 5;
  localparam int unsigned W_SRC_LO = 6;
  localparam int unsigned W_SRC_HI = 7;
  localparam int unsigned W_AREA   = 64;  // byte 0x100

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_GIE, SEL_IIE, SEL_IIS,
    SEL_TYPE, SEL_VER, SEL_SRC_LO, SEL_SRC_HI, SEL_CWORD, SEL_JOB
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e         sel;
    logic [IDX_W-1:0] idx;
  } reg_hit_t;

  function automatic reg_hit_t decode_word(input logic [WADR_W-1:0] waddr,
                                           input int unsigned ctl_words,
                                           input int unsigned job_words);
    reg_hit_t    h;
    int unsigned w;
    w     = 32'(waddr);
    h.sel = SEL_NONE;
    h.idx = '0;
    if (w == W_CTRL)        h.sel = SEL_CTRL;
    else if (w == W_GIE)    h.sel = SEL_GIE;
    else if (w == W_IIE)    h.sel = SEL_IIE;
    else if (w == W_IIS)    h.sel = SEL_IIS;
    else if (w == W_TYPE)   h.sel = SEL_TYPE;
    else if (w == W_VER)    h.sel = SEL_VER;
    else if (w == W_SRC_LO) h.sel = SEL_SRC_LO;
    else if (w == W_SRC_HI) h.sel = SEL_SRC_HI;
    else if (w >= W_AREA && w < W_AREA + ctl_words) begin
      h.sel = SEL_CWORD;
      h.idx = IDX_W'(w - W_AREA);
    end else if (w >= W_AREA + ctl_words && w < W_AREA + ctl_words + job_words) begin
      h.sel = SEL_JOB;
      h.idx = IDX_W'(w - W_AREA - ctl_words);
    end
    return h;
  endfunction

endpackage

// File: rtl/act_axil_port.sv
`timescale 1ns/1ps
module act_axil_port
  import act_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [3:0]        wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              wr_go,
  output logic [ADDR_W-3:0] wr_waddr,
  output logic [DATA_W-1:0] wr_data,
  output logic [3:0]        wr_strb,
  output logic              rd_go,
  output logic [ADDR_W-3:0] rd_waddr,
  input  logic [DATA_W-1:0] rd_word
);

  logic bvalid_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic unused_lsb;

  assign unused_lsb = ^{awaddr[1:0], araddr[1:0]};

  // write path: address and data must arrive together
  assign wr_go    = awvalid & wvalid & ~bvalid_q;
  assign awready  = wr_go;
  assign wready   = wr_go;
  assign wr_waddr = awaddr[ADDR_W-1:2];
  assign wr_data  = wdata;
  assign wr_strb  = wstrb;

  // read path: one read in flight
  assign arready  = ~rvalid_q;
  assign rd_go    = arvalid & ~rvalid_q;
  assign rd_waddr = araddr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_go)       bvalid_q <= 1'b1;
      else if (bready) bvalid_q <= 1'b0;
      if (rd_go) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_word;
      end else if (rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;

endmodule

// File: rtl/act_ctl_core.sv
`timescale 1ns/1ps
module act_ctl_core
  import act_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  reg_sel_e          wr_sel,
  input  logic              wr_lane0,
  input  logic [7:0]        wr_byte,
  input  logic              rd_go,
  input  reg_sel_e          rd_sel,
  input  logic              done_i,
  input  logic              idle_i,
  input  logic              ready_i,
  output logic              start_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] ctrl_word,
  output logic [DATA_W-1:0] gie_word,
  output logic [DATA_W-1:0] iie_word,
  output logic [DATA_W-1:0] iis_word
);

  localparam int unsigned NSRC = 2;  // 0: done, 1: ready

  logic start_q, donest_q, auto_q, gie_q;
  logic done_q, ready_q;
  logic [NSRC-1:0] iie_q, iis_q, src_rise, iis_clr;
  logic wr_ctrl, wr_gie, wr_iie, wr_iis, rd_ctrl;

  assign wr_ctrl = wr_go & wr_lane0 & (wr_sel == SEL_CTRL);
  assign wr_gie  = wr_go & wr_lane0 & (wr_sel == SEL_GIE);
  assign wr_iie  = wr_go & wr_lane0 & (wr_sel == SEL_IIE);
  assign wr_iis  = wr_go & wr_lane0 & (wr_sel == SEL_IIS);
  assign rd_ctrl = rd_go & (rd_sel == SEL_CTRL);

  assign src_rise = {ready_i & ~ready_q, done_i & ~done_q};
  assign iis_clr  = wr_iis ? wr_byte[NSRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      ready_q  <= 1'b0;
      start_q  <= 1'b0;
      donest_q <= 1'b0;
      auto_q   <= 1'b0;
      gie_q    <= 1'b0;
      iie_q    <= '0;
    end else begin
      done_q  <= done_i;
      ready_q <= ready_i;
      // launch handshake: ready retires, write or relaunch sets (set wins)
      if (start_q && ready_i) start_q <= 1'b0;
      if ((wr_ctrl && wr_byte[0]) || (src_rise[0] && auto_q)) start_q <= 1'b1;
      // sticky completion, consumed by a control read
      if (rd_ctrl)     donest_q <= 1'b0;
      if (src_rise[0]) donest_q <= 1'b1;
      if (wr_ctrl) auto_q <= wr_byte[7];
      if (wr_gie)  gie_q  <= wr_byte[0];
      if (wr_iie)  iie_q  <= wr_byte[NSRC-1:0];
    end
  end

  // one status flop per interrupt source
  for (genvar s = 0; s < NSRC; s++) begin : g_iis
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           iis_q[s] <= 1'b0;
      else if (src_rise[s]) iis_q[s] <= 1'b1;
      else if (iis_clr[s])  iis_q[s] <= 1'b0;
    end
  end

  assign irq_o   = gie_q & (|(iie_q & iis_q));
  assign start_o = start_q;

  assign ctrl_word = {24'd0, auto_q, 3'd0, ready_i, idle_i, donest_q, start_q};
  assign gie_word  = {31'd0, gie_q};
  assign iie_word  = {{(DATA_W-NSRC){1'b0}}, iie_q};
  assign iis_word  = {{(DATA_W-NSRC){1'b0}}, iis_q};

endmodule

// File: rtl/act_word_store.sv
`timescale 1ns/1ps
module act_word_store
  import act_regs_pkg::*;
#(
  parameter int unsigned WORDS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [3:0]              wr_strb,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]       rd_data,
  output logic [WORDS*DATA_W-1:0] words_o
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [WORDS-1:0][DATA_W-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < LANES; b++) begin
          if (wr_idx == IDX_W'(w) && wr_strb[b]) mem_q[w][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_idx == IDX_W'(w)) rd_data = mem_q[w];
    end
  end

  assign words_o = mem_q;

endmodule

// File: rtl/act_ctl_regs.sv
`timescale 1ns/1ps
module act_ctl_regs
  import act_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned CTL_WORDS   = 4,
  parameter int unsigned JOB_WORDS   = 27,
  parameter logic [31:0] ACTION_TYPE = 32'h1014_1008,
  parameter logic [31:0] ACTION_VER  = 32'h0000_0001,
  parameter logic [63:0] IRQ_SRC_ADR = 64'h0000_0000_0000_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        s_awvalid,
  output logic                        s_awready,
  input  logic [ADDR_W-1:0]           s_awaddr,
  input  logic                        s_wvalid,
  output logic                        s_wready,
  input  logic [31:0]                 s_wdata,
  input  logic [3:0]                  s_wstrb,
  output logic                        s_bvalid,
  input  logic                        s_bready,
  output logic [1:0]                  s_bresp,
  input  logic                        s_arvalid,
  output logic                        s_arready,
  input  logic [ADDR_W-1:0]           s_araddr,
  output logic                        s_rvalid,
  input  logic                        s_rready,
  output logic [31:0]                 s_rdata,
  output logic [1:0]                  s_rresp,
  output logic                        act_start_o,
  input  logic                        act_done_i,
  input  logic                        act_idle_i,
  input  logic                        act_ready_i,
  output logic                        irq_o,
  output logic [CTL_WORDS*32-1:0]     ctl_words_o,
  output logic [JOB_WORDS*32-1:0]     job_words_o
);

  localparam int unsigned PAD_W = WADR_W - (ADDR_W - 2);

  logic              wr_go, rd_go;
  logic [ADDR_W-3:0] wr_waddr, rd_waddr;
  logic [31:0]       wr_data, rd_word;
  logic [3:0]        wr_strb;
  reg_hit_t          wr_hit, rd_hit;
  logic [31:0]       ctrl_word, gie_word, iie_word, iis_word, cw_rd, job_rd;

  act_axil_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .wr_go(wr_go), .wr_waddr(wr_waddr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_go(rd_go), .rd_waddr(rd_waddr), .rd_word(rd_word)
  );

  assign wr_hit = decode_word({{PAD_W{1'b0}}, wr_waddr}, CTL_WORDS, JOB_WORDS);
  assign rd_hit = decode_word({{PAD_W{1'b0}}, rd_waddr}, CTL_WORDS, JOB_WORDS);

  act_ctl_core u_core (
    .clk(clk), .rst_n(rst_n),
    .wr_go(wr_go), .wr_sel(wr_hit.sel), .wr_lane0(wr_strb[0]), .wr_byte(wr_data[7:0]),
    .rd_go(rd_go), .rd_sel(rd_hit.sel),
    .done_i(act_done_i), .idle_i(act_idle_i), .ready_i(act_ready_i),
    .start_o(act_start_o), .irq_o(irq_o),
    .ctrl_word(ctrl_word), .gie_word(gie_word), .iie_word(iie_word), .iis_word(iis_word)
  );

  act_word_store #(.WORDS(CTL_WORDS)) u_cwords (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_go && wr_hit.sel == SEL_CWORD), .wr_idx(wr_hit.idx),
    .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_hit.idx), .rd_data(cw_rd), .words_o(ctl_words_o)
  );

  act_word_store #(.WORDS(JOB_WORDS)) u_jwords (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_go && wr_hit.sel == SEL_JOB), .wr_idx(wr_hit.idx),
    .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_hit.idx), .rd_data(job_rd), .words_o(job_words_o)
  );

  always_comb begin
    unique case (rd_hit.sel)
      SEL_CTRL:   rd_word = ctrl_word;
      SEL_GIE:    rd_word = gie_word;
      SEL_IIE:    rd_word = iie_word;
      SEL_IIS:    rd_word = iis_word;
      SEL_TYPE:   rd_word = ACTION_TYPE;
      SEL_VER:    rd_word = ACTION_VER;
      SEL_SRC_LO: rd_word = IRQ_SRC_ADR[31:0];
      SEL_SRC_HI: rd_word = IRQ_SRC_ADR[63:32];
      SEL_CWORD:  rd_word = cw_rd;
      SEL_JOB:    rd_word = job_rd;
      default:    rd_word = '0;
    endcase
  end

endmodule

// File: rtl/act_ctl_regs_chk.sv
`timescale 1ns/1ps
module act_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata,
  input logic [1:0]  rresp,
  input logic        awvalid,
  input logic        wvalid,
  input logic        start_o,
  input logic        done_i,
  input logic        ready_i,
  input logic        irq_o,
  input logic [1:0]  iis_st,
  input logic        auto_st
);

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata)); // R1
  AST_BRESP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid); // R1
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> bresp == 2'b00); // R2
  AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rresp == 2'b00); // R2
  AST_START_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o && ready_i && !done_i && !(awvalid && wvalid) |=> !start_o); // R3
  AST_AUTO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_i) && auto_st |=> start_o); // R5
  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_i) |=> iis_st[0]); // R8
  AST_READY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_i) |=> iis_st[1]); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> iis_st != 2'b00); // R9

endmodule

bind act_ctl_regs act_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
  .awvalid(s_awvalid), .wvalid(s_wvalid),
  .start_o(act_start_o), .done_i(act_done_i), .ready_i(act_ready_i),
  .irq_o(irq_o), .iis_st(u_core.iis_q), .auto_st(u_core.auto_q)
);

// File: tb/act_ctl_regs_bench.sv
`timescale 1ns/1ps
module act_ctl_regs_bench;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned JOBW   = 27;
  localparam logic [31:0] TYPE_C = 32'h1014_1008;
  localparam logic [31:0] VER_C  = 32'h0002_0103;
  localparam logic [63:0] SRC_C  = 64'h89AB_CDEF_0123_4567;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic start, done = 0, idle = 0, ready = 0, irq;
  logic [4*32-1:0]    ctl_words;
  logic [JOBW*32-1:0] job_words;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  act_ctl_regs #(.ADDR_W(ADDR_W), .CTL_WORDS(4), .JOB_WORDS(JOBW),
                 .ACTION_TYPE(TYPE_C), .ACTION_VER(VER_C), .IRQ_SRC_ADR(SRC_C)) u_act_ctl_regs (
    .clk(clk), .rst_n(rst_n),
    .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
    .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
    .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
    .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
    .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
    .act_start_o(start), .act_done_i(done), .act_idle_i(idle), .act_ready_i(ready),
    .irq_o(irq), .ctl_words_o(ctl_words), .job_words_o(job_words)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each read data beat
  always @(negedge clk) begin
    if (rst_n && rvalid && rready) begin
      chk("R2 rresp", {30'd0, rresp}, 32'd0);
      if (exp_q.size() == 0) begin
        chk("R1 unexpected read beat", rdata, 32'hxxxx_xxxx);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic axi_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    while (bvalid) @(negedge clk);
    awvalid = 1; wvalid = 1; awaddr = a; wdata = d; wstrb = s;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    chk("R1 bvalid after write", {31'd0, bvalid}, 32'd1);
    chk("R2 bresp", {30'd0, bresp}, 32'd0);
  endtask

  task automatic axi_read(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag,
                          input bit with_done);
    @(negedge clk);
    while (rvalid) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    arvalid = 1; araddr = a;
    if (with_done) done = 1;
    @(negedge clk);
    arvalid = 0;
    if (with_done) done = 0;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  task automatic pulse_ready();
    @(negedge clk); ready = 1;
    @(negedge clk); ready = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset start", {31'd0, start}, 32'd0);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);
    chk("R1 reset bvalid", {31'd0, bvalid}, 32'd0);
    chk("R1 reset rvalid", {31'd0, rvalid}, 32'd0);

    // R10 constant words, writes ignored
    axi_read(12'h010, TYPE_C, "R10 type", 0);
    axi_read(12'h014, VER_C, "R10 version", 0);
    axi_read(12'h018, SRC_C[31:0], "R10 src low", 0);
    axi_read(12'h01C, SRC_C[63:32], "R10 src high", 0);
    axi_write(12'h010, 32'hDEAD_BEEF, 4'hF);
    axi_read(12'h010, TYPE_C, "R10 type after write", 0);

    // R13 unmapped
    axi_write(12'h024, 32'hFFFF_FFFF, 4'hF);
    axi_read(12'h024, 32'd0, "R13 unmapped 0x24", 0);
    axi_read(12'h17C, 32'd0, "R13 unmapped 0x17C", 0);

    // R6 live idle and ready
    idle = 1;
    axi_read(12'h000, 32'h4, "R6 idle bit", 0);
    @(negedge clk); ready = 1;
    axi_read(12'h000, 32'hC, "R6 ready bit", 0);
    @(negedge clk); ready = 0;

    // R3 launch and retire
    axi_write(12'h000, 32'h1, 4'hF);
    chk("R3 start set", {31'd0, start}, 32'd1);
    axi_read(12'h000, 32'h5, "R3 start readback", 0);
    axi_write(12'h000, 32'h0, 4'hF);
    chk("R3 write 0 keeps start", {31'd0, start}, 32'd1);
    pulse_ready();
    chk("R3 start retired by ready", {31'd0, start}, 32'd0);
    axi_read(12'h00C, 32'h2, "R8 ready status", 0);

    // R4 sticky done cleared by read
    pulse_done();
    axi_read(12'h000, 32'h6, "R4 done set", 0);
    axi_read(12'h000, 32'h4, "R4 done cleared", 0);
    axi_read(12'h00C, 32'h3, "R8 both status", 0);

    // R7 R8 R9 enables and status
    axi_write(12'h008, 32'h1, 4'hF);
    chk("R9 no irq without global", {31'd0, irq}, 32'd0);
    axi_write(12'h004, 32'h1, 4'hF);
    chk("R9 irq on", {31'd0, irq}, 32'd1);
    axi_read(12'h004, 32'h1, "R7 global enable", 0);
    axi_read(12'h008, 32'h1, "R7 source enable", 0);
    axi_write(12'h00C, 32'h1, 4'hF);
    chk("R9 irq off after clear", {31'd0, irq}, 32'd0);
    axi_read(12'h00C, 32'h2, "R8 w1c done", 0);
    axi_write(12'h008, 32'h2, 4'hF);
    chk("R9 irq via ready source", {31'd0, irq}, 32'd1);
    axi_write(12'h00C, 32'h2, 4'hF);
    chk("R9 irq off again", {31'd0, irq}, 32'd0);
    axi_read(12'h00C, 32'h0, "R8 w1c ready", 0);

    // R5 auto-restart
    axi_write(12'h000, 32'h80, 4'hF);
    axi_read(12'h000, 32'h84, "R5 auto flag", 0);
    pulse_done();
    chk("R5 relaunch", {31'd0, start}, 32'd1);
    axi_read(12'h000, 32'h87, "R5 control after relaunch", 0);
    pulse_ready();
    chk("R3 retire after relaunch", {31'd0, start}, 32'd0);
    axi_write(12'h000, 32'h00, 4'hF);
    pulse_done();
    chk("R5 no relaunch when off", {31'd0, start}, 32'd0);
    axi_read(12'h000, 32'h6, "R5 done without relaunch", 0);

    // R4 read coinciding with a done edge
    axi_read(12'h000, 32'h4, "R4 read at done edge", 1);
    axi_read(12'h000, 32'h6, "R4 done kept", 0);
    axi_read(12'h000, 32'h4, "R4 done consumed", 0);

    // R11 control words
    axi_write(12'h100, 32'hABCD_1234, 4'hF);
    axi_read(12'h100, 32'hABCD_1234, "R11 word0", 0);
    chk("R11 short type", {24'd0, ctl_words[7:0]}, 32'h34);
    chk("R11 flags", {24'd0, ctl_words[15:8]}, 32'h12);
    chk("R11 seq", {16'd0, ctl_words[31:16]}, 32'hABCD);
    axi_write(12'h104, 32'h1122_3344, 4'hF);
    axi_write(12'h104, 32'hFFFF_FFFF, 4'h3);
    axi_read(12'h104, 32'h1122_FFFF, "R11 retc strobes", 0);
    chk("R11 retc output", ctl_words[63:32], 32'h1122_FFFF);

    // R12 job words
    axi_write(12'h110, 32'h0BAD_F00D, 4'hF);
    axi_write(12'h178, 32'hC001_D00D, 4'hF);
    axi_write(12'h178, 32'h0000_0000, 4'h8);
    axi_read(12'h110, 32'h0BAD_F00D, "R12 first job word", 0);
    axi_read(12'h178, 32'h0001_D00D, "R12 last job word", 0);
    chk("R12 first output", job_words[31:0], 32'h0BAD_F00D);
    chk("R12 last output", job_words[26*32 +: 32], 32'h0001_D00D);

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule